// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block produces the word address for a synchronous memory that serves four-beat bursts. An external address is captured whenever either of two start strobes is high. After that, the two least significant address bits step through a four-beat sequence, one step for each clock in which the advance input is high. The upper address bits stay at the captured value for the whole burst.

A strap-style order input selects how the low bits step. With the input high, the beat number is XORed with the starting low bits (interleaved order). With the input low, the beat number is added to the starting low bits modulo four (linear order). Interleaved order is the recommended tie-off. Bursting is optional: a fresh address may be loaded on every clock with no idle cycle. Reads that do not enable the output still advance the sequence like any other access, because the block only sees the advance input.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, addr_out is all zeros.
- R2: If start_a or start_b is high at a rising clock edge, addr_out equals addr_in (as sampled at that edge) from that edge on, and the beat number restarts at 0.
- R3: If a start strobe and adv are both high at the same edge, the load of R2 takes place and the advance is discarded.
- R4: If adv is high and both strobes are low at an edge, the beat number goes up by one modulo 4. After four advances it is back at 0, so the addresses wrap within the same four-word block.
- R5: When ilv_order is 0 (linear), addr_out[1:0] = (start[1:0] + beat) mod 4.
- R6: When ilv_order is 1 (interleaved), addr_out[1:0] = start[1:0] XOR beat.
- R7: If neither strobe nor adv is high at an edge, the beat number and the start address are kept, so addr_out does not change while ilv_order is steady.
- R8: addr_out[AW-1:2] changes only at an edge where a start strobe is high.
- R9: Loads on consecutive edges each take effect, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_a | input | 1 | First burst start strobe |
| start_b | input | 1 | Second burst start strobe |
| adv | input | 1 | Advance to the next beat |
| ilv_order | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | AW | External start address |
| addr_out | output | AW | Current burst address |

## Verification
Two functions can fall in the same cycle: a burst load and an advance. Directed cases drive each strobe together with adv in the middle of a burst. The random phase draws strobes and advance independently, so the two overlap often. The bench judges each such cycle against its model, which expects beat 0 at the newly loaded address and no step. It also checks both orders across full wraps, and order changes in the middle of a burst, where the output has to follow the new order at once.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_a,
  input  logic          start_b,
  input  logic          adv,
  input  logic          ilv_order,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);

  localparam int BW = 2;

  logic [AW-1:0] start_q;
  logic [BW-1:0] beat_q;
  logic          load;
  logic [BW-1:0] low_lin;
  logic [BW-1:0] low_ilv;

  assign load = start_a | start_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= addr_in;
      beat_q  <= '0;
    end else if (adv) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign low_lin  = start_q[BW-1:0] + beat_q;
  assign low_ilv  = start_q[BW-1:0] ^ beat_q;
  assign addr_out = {start_q[AW-1:BW], ilv_order ? low_ilv : low_lin};

endmodule

module burst_addr_gen_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_a,
  input logic          start_b,
  input logic          adv,
  input logic          ilv_order,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out
);

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_a || start_b) |=> addr_out == $past(addr_in)); // R2

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a && !start_b) |=> addr_out[AW-1:2] == $past(addr_out[AW-1:2])); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a && !start_b && !adv) |=> (!$stable(ilv_order) || $stable(addr_out))); // R7

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a && !start_b && adv && !ilv_order) |=>
      (ilv_order || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1)); // R5

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_a(start_a), .start_b(start_b),
  .adv(adv), .ilv_order(ilv_order), .addr_in(addr_in), .addr_out(addr_out)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_a = 1'b0, start_b = 1'b0, adv = 1'b0, ilv_order = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] m_start = '0;
  logic [1:0]    m_beat = '0;

  burst_addr_gen #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start_a(start_a), .start_b(start_b),
    .adv(adv), .ilv_order(ilv_order), .addr_in(addr_in), .addr_out(addr_out)
  );

  always #4 clk = ~clk;

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] s, logic [1:0] b, logic ord);
    logic [1:0] lo;
    lo = ord ? (s[1:0] ^ b) : (s[1:0] + b);
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      fails++;
      $display("FAIL %s: addr_out=%h expected=%h", tag, addr_out, exp);
    end
  endtask

  task automatic step(logic sa, logic sb, logic a, logic ord, logic [AW-1:0] ain);
    @(negedge clk);
    start_a = sa; start_b = sb; adv = a; ilv_order = ord; addr_in = ain;
    @(posedge clk);
    if (sa || sb) begin m_start = ain; m_beat = 2'd0; end
    else if (a) m_beat = m_beat + 2'd1;
  endtask

  task automatic step_check(string tag, logic sa, logic sb, logic a, logic ord, logic [AW-1:0] ain);
    step(sa, sb, a, ord, ain);
    #2 check(tag, expect_addr(m_start, m_beat, ord));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] prev;
    void'($urandom(32'h1bad5eed));
    repeat (3) @(posedge clk);
    #2 check("R1 in reset", '0);
    @(negedge clk);
    rst_n = 1'b1;
    addr_in = 20'hABCDE;
    @(posedge clk);
    #2 check("R1 after release", '0);

    step_check("R2 start_a load", 1, 0, 0, 1, 20'h12345);
    for (int i = 1; i <= 4; i++) step_check("R6 interleaved beat", 0, 0, 1, 1, 20'h0);
    step_check("R4 wrap back to start", 0, 0, 0, 1, 20'hFFFFF);
    step_check("R2 start_b load", 0, 1, 0, 0, 20'h5432E);
    for (int i = 1; i <= 5; i++) step_check("R5 linear beat with wrap", 0, 0, 1, 0, 20'h0);
    check("R8 upper fixed after wrap", {20'h5432E >> 2, 2'd3});
    step_check("R7 idle hold", 0, 0, 0, 0, 20'h77777);
    step_check("R7 idle hold again", 0, 0, 0, 0, 20'h88888);
    step_check("R3 start_a beats adv", 1, 0, 1, 1, 20'h0F0F1);
    check("R3 start_a beats adv exact", 20'h0F0F1);
    step_check("R4 advance", 0, 0, 1, 1, 20'h0);
    step_check("R3 start_b beats adv", 0, 1, 1, 1, 20'h3C3C2);
    check("R3 start_b beats adv exact", 20'h3C3C2);
    step_check("R9 back-to-back load 1", 1, 0, 0, 0, 20'h00001);
    step_check("R9 back-to-back load 2", 0, 1, 0, 0, 20'h00002);
    step_check("R9 back-to-back load 3", 1, 1, 0, 0, 20'hFFFFF);
    step_check("R6 order switch mid-burst", 0, 0, 1, 0, 20'h0);
    step(0, 0, 0, 1, 20'h0);
    #2 check("R6 order switch to interleaved", expect_addr(m_start, m_beat, 1));

    for (int n = 0; n < 3000; n++) begin
      logic sa, sb, a, ord;
      logic [AW-1:0] ain;
      sa = ($urandom % 6) == 0;
      sb = ($urandom % 6) == 0;
      a  = ($urandom % 3) != 0;
      ord = ($urandom % 8) != 0 ? ilv_order : ~ilv_order;
      ain = AW'($urandom);
      prev = addr_out;
      if (sa || sb) step_check(a ? "R3 random load with adv" : "R2 random load", sa, sb, a, ord, ain);
      else begin
        step_check(a ? (ord ? "R6 random interleaved" : "R5 random linear") : "R7 random hold",
                   sa, sb, a, ord, ain);
        checks++;
        if (addr_out[AW-1:2] !== prev[AW-1:2]) begin
          fails++;
          $display("FAIL R8: upper=%h expected=%h", addr_out[AW-1:2], prev[AW-1:2]);
        end
      end
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #2 check("R1 re-reset", '0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule